// File: doc/BRIEF.md
# Sequential Unsigned Multiply-Divide Unit

This block performs unsigned 8x8 multiplication and 16/8 division over several clock cycles. A caller presents the operands together with an operation select and pulses a start strobe. The unit then reports busy and runs for a fixed number of clocks. It finishes with a one-cycle done strobe, and in that same cycle the result outputs take their new values.

Multiply gives a 16-bit product. Divide gives a 16-bit quotient and an 8-bit remainder. The quotient shares the word result output with the product, and the remainder has a byte output of its own. The multiplier uses shift-and-add and the divider uses restoring shift-and-subtract. Each pads its iterations out to the operation's fixed latency, so a caller can rely on the clock count whatever the operands are. Flags, sign handling and instruction decode belong to the surrounding datapath.

Top module: `mdu_seq`

## Requirements
- R1: With `op_div_i` = 0 (multiply), the completed operation drives `word_o` with the full 16-bit unsigned product `mul_a_i * mul_b_i`.
- R2: A multiply accepted at a clock edge raises `done_o` exactly 16 clock cycles after that edge, and at no other time.
- R3: With `op_div_i` = 1 (divide) and a nonzero divisor, the completed operation drives `word_o` with `div_n_i / div_d_i` (16-bit quotient) and `rem_o` with `div_n_i % div_d_i`.
- R4: A divide accepted at a clock edge raises `done_o` exactly 25 clock cycles after that edge.
- R5: A divide by zero returns a quotient of 16'hFFFF and a remainder equal to `div_n_i[7:0]`, and it still takes 25 cycles.
- R6: A start strobe that arrives while `busy_o` is high is ignored. The running operation's result and timing are unchanged, and `busy_o` falls only together with a rising `done_o`.
- R7: `word_o` and `rem_o` change only in the done cycle. A multiply leaves `rem_o` holding its previous value.
- R8: `busy_o` is low in the done cycle. A start presented in that cycle is accepted, so operations can run back to back without a gap.
- R9: After a synchronous reset, `busy_o`, `done_o`, `word_o` and `rem_o` are all zero.
- R10: `done_o` is a single-cycle pulse and is never high together with `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| mul_a_i | input | 8 | Multiply operand (accumulator byte) |
| mul_b_i | input | 8 | Multiply operand (second byte) |
| div_n_i | input | 16 | Divide dividend |
| div_d_i | input | 8 | Divide divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| word_o | output | 16 | Product or quotient |
| rem_o | output | 8 | Remainder of the last divide |

## Verification
Completion and acceptance can fall in the same cycle. In the cycle where `done_o` rises, busy has already dropped, so a start held or presented in that cycle begins the next operation. The bench provokes this two ways: it waits for `done_o` and drives a new start at once, and it holds start high for long stretches so that every done cycle is also an acceptance cycle. A behavioural model settles which starts count. It is compared with busy, done and both results on every clock, so a lost or doubled acceptance shows up as a shifted done strobe or a stale result.

// File: rtl/mdu_pkg.sv
// Package mdu_pkg
// Shared widths, latencies and the operation encoding for the
// sequential multiply-divide unit. Latencies count clocks from the
// accepting edge to the cycle in which the done strobe is high.
package mdu_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int MUL_CYC   = 16;
    localparam int DIV_CYC   = 25;
    localparam int MUL_STEPS = BYTE_W;
    localparam int DIV_STEPS = WORD_W;
    localparam int MAX_CYC   = (DIV_CYC > MUL_CYC) ? DIV_CYC : MUL_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mdu_op_e;

endpackage

// File: rtl/mdu_ctrl.sv
// Module mdu_ctrl
// Sequencer: accepts a start only when idle, counts elapsed clocks,
// enables the datapath iterations for the first STEPS cycles and
// closes the operation at its fixed latency.
// Assumes each operation's iteration count is below its latency.
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int MUL_LAT = MUL_CYC,
    parameter int DIV_LAT = DIV_CYC,
    parameter int MUL_IT  = MUL_STEPS,
    parameter int DIV_IT  = DIV_STEPS,
    parameter int CW      = CNT_W
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  mdu_op_e op_i,
    output logic    accept_o,
    output logic    step_o,
    output logic    finish_o,
    output logic    busy_o,
    output logic    done_o,
    output mdu_op_e op_q_o
);

    localparam logic [CW-1:0] MUL_LAST = CW'(MUL_LAT - 2);
    localparam logic [CW-1:0] DIV_LAST = CW'(DIV_LAT - 2);
    localparam logic [CW-1:0] MUL_NIT  = CW'(MUL_IT);
    localparam logic [CW-1:0] DIV_NIT  = CW'(DIV_IT);

    logic [CW-1:0] elapsed_q;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] iter_cnt;

    // Pick the closing count and iteration count of the running operation.
    always_comb begin
        last_cnt = (op_q_o == OP_DIV) ? DIV_LAST : MUL_LAST;
        iter_cnt = (op_q_o == OP_DIV) ? DIV_NIT  : MUL_NIT;
    end

    assign accept_o = start_i && !busy_o;
    assign step_o   = busy_o && (elapsed_q < iter_cnt);
    assign finish_o = busy_o && (elapsed_q == last_cnt);

    // Track busy, the elapsed count, the latched operation and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            elapsed_q <= '0;
            op_q_o    <= OP_MUL;
        end else begin
            done_o <= finish_o;
            if (busy_o) begin
                elapsed_q <= elapsed_q + 1'b1;
                if (finish_o) begin
                    busy_o <= 1'b0;
                end
            end else if (start_i) begin
                busy_o    <= 1'b1;
                elapsed_q <= '0;
                op_q_o    <= op_i;
            end
        end
    end

endmodule

// File: rtl/mdu_mul_core.sv
// Module mdu_mul_core
// Shift-and-add unsigned multiplier: one multiplier bit per step,
// W steps for a 2W-bit product. Loads on load_i, iterates on step_i,
// and holds its product otherwise.
module mdu_mul_core #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);

    logic [W-1:0] mcand_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;
    logic [W:0]   sum;

    // Add the multiplicand into the upper half when the current bit is set.
    always_comb begin
        sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    end

    // Load operands, then shift the partial product right once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (load_i) begin
            mcand_q <= a_i;
            hi_q    <= '0;
            lo_q    <= b_i;
        end else if (step_i) begin
            hi_q <= sum[W:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
        end
    end

    assign prod_o = {hi_q, lo_q};

endmodule

// File: rtl/mdu_div_core.sv
// Module mdu_div_core
// Restoring shift-subtract divider: 2W-bit dividend by W-bit divisor,
// one quotient bit per step, 2W steps. A zero divisor makes every
// trial subtraction succeed, giving an all-ones quotient and the low
// dividend byte as remainder without any special path.
module mdu_div_core #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [2*W-1:0] n_i,
    input  logic [W-1:0]   d_i,
    output logic [2*W-1:0] quot_o,
    output logic [W-1:0]   rem_o,
    output logic [W-1:0]   dvs_o
);

    logic [2*W-1:0] q_q;
    logic [W-1:0]   r_q;
    logic [W-1:0]   d_q;
    logic [W:0]     trial;
    logic           fits;
    logic [W:0]     r_nxt;

    // Form the shifted partial remainder and test it against the divisor.
    always_comb begin
        trial = {r_q, q_q[2*W-1]};
        fits  = (trial >= {1'b0, d_q});
        r_nxt = fits ? (trial - {1'b0, d_q}) : trial;
    end

    // Load the dividend, then develop one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
            r_q <= '0;
            d_q <= '0;
        end else if (load_i) begin
            q_q <= n_i;
            r_q <= '0;
            d_q <= d_i;
        end else if (step_i) begin
            q_q <= {q_q[2*W-2:0], fits};
            r_q <= W'(r_nxt);
        end
    end

    assign quot_o = q_q;
    assign rem_o  = r_q;
    assign dvs_o  = d_q;

endmodule

// File: rtl/mdu_seq.sv
// Module mdu_seq
// Top of the sequential unsigned multiply-divide unit. Both cores load
// on an accepted start; only the core selected by the latched operation
// feeds the result registers, which are written on the finishing edge
// alone. Assumes operands are valid in the start cycle only.
module mdu_seq
    import mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_div_i,
    input  logic [BYTE_W-1:0] mul_a_i,
    input  logic [BYTE_W-1:0] mul_b_i,
    input  logic [WORD_W-1:0] div_n_i,
    input  logic [BYTE_W-1:0] div_d_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o,
    output logic [BYTE_W-1:0] rem_o
);

    logic              accept;
    logic              step;
    logic              finish;
    mdu_op_e           op_q;
    logic              mul_step;
    logic              div_step;
    logic [WORD_W-1:0] prod;
    logic [WORD_W-1:0] quot;
    logic [BYTE_W-1:0] remain;
    logic [BYTE_W-1:0] dvs_q;

    mdu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (mdu_op_e'(op_div_i)),
        .accept_o (accept),
        .step_o   (step),
        .finish_o (finish),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .op_q_o   (op_q)
    );

    assign mul_step = step && (op_q == OP_MUL);
    assign div_step = step && (op_q == OP_DIV);

    mdu_mul_core #(.W(BYTE_W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (mul_step),
        .a_i    (mul_a_i),
        .b_i    (mul_b_i),
        .prod_o (prod)
    );

    mdu_div_core #(.W(BYTE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (div_step),
        .n_i    (div_n_i),
        .d_i    (div_d_i),
        .quot_o (quot),
        .rem_o  (remain),
        .dvs_o  (dvs_q)
    );

    // Commit the finished operation's results on the closing edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            rem_o  <= '0;
        end else if (finish) begin
            if (op_q == OP_DIV) begin
                word_o <= quot;
                rem_o  <= remain;
            end else begin
                word_o <= prod;
            end
        end
    end

endmodule

// File: rtl/mdu_seq_chk.sv
// Module mdu_seq_chk
// Property checker for mdu_seq, bound to every instance. Keeps its own
// count of cycles since acceptance to judge the fixed latencies.
module mdu_seq_chk
    import mdu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input mdu_op_e           op_q,
    input logic [BYTE_W-1:0] dvs_q,
    input logic [WORD_W-1:0] word_o,
    input logic [BYTE_W-1:0] rem_o
);

    logic [CNT_W-1:0] since_q;

    // Count clocks since the most recent accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (start_i && !busy_o) begin
            since_q <= CNT_W'(1);
        end else if (busy_o) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_MUL) |-> since_q == CNT_W'(MUL_CYC)); // R2
    AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_DIV) |-> since_q == CNT_W'(DIV_CYC)); // R4
    AST_DIVZERO_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_DIV && dvs_q == '0) |-> word_o == '1); // R5
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(word_o) && $stable(rem_o))); // R7
    AST_MUL_KEEPS_REM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_MUL) |-> $stable(rem_o)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o)); // R10

endmodule

bind mdu_seq mdu_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .op_q    (op_q),
    .dvs_q   (dvs_q),
    .word_o  (word_o),
    .rem_o   (rem_o)
);

// File: tb/mdu_seq_tb.sv
`timescale 1ns/1ps
module mdu_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic [7:0]  ma = '0;
    logic [7:0]  mb = '0;
    logic [15:0] dn = '0;
    logic [7:0]  dd = '0;
    logic        busy;
    logic        done;
    logic [15:0] word;
    logic [7:0]  rem;

    integer total = 0;
    integer bad = 0;
    bit     finished = 1'b0;

    // Reference model state
    integer m_busy = 0, m_done = 0, m_left = 0, m_word = 0, m_rem = 0;
    integer m_op = 0, m_divz = 0;
    integer p_word = 0, p_rem = 0, p_op = 0, p_z = 0;

    always #2.5 clk = ~clk;

    mdu_seq u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .op_div_i (op_div),
        .mul_a_i  (ma),
        .mul_b_i  (mb),
        .div_n_i  (dn),
        .div_d_i  (dd),
        .busy_o   (busy),
        .done_o   (done),
        .word_o   (word),
        .rem_o    (rem)
    );

    task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: advances once per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0; m_word = 0; m_rem = 0;
            m_op = 0; m_divz = 0;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_word = p_word;
                    if (p_op != 0) m_rem = p_rem;
                    m_op = p_op;
                    m_divz = p_z;
                end
            end else if (start) begin
                m_busy = 1;
                p_op = op_div;
                if (op_div) begin
                    m_left = 24;
                    p_z = (dd == 0);
                    if (dd == 0) begin
                        p_word = 16'hFFFF;
                        p_rem = dn & 8'hFF;
                    end else begin
                        p_word = dn / dd;
                        p_rem = dn % dd;
                    end
                end else begin
                    m_left = 15;
                    p_z = 0;
                    p_word = ma * mb;
                end
            end
        end
    end

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == m_busy[0], "R6 busy", busy, m_busy);
            chk(done == m_done[0], (p_op != 0) ? "R4 done" : "R2 done", done, m_done);
            chk(word == m_word[15:0],
                (m_op == 0) ? "R1 word" : ((m_divz != 0) ? "R5 word" : "R3 word"),
                word, m_word);
            chk(rem == m_rem[7:0], (m_op == 0) ? "R7 rem" : "R3 rem", rem, m_rem);
            chk(!(busy && done), "R10 busy with done", {busy, done}, 2'b01);
        end
    end

    task automatic drive(input bit dv, input integer a, input integer b,
                         input integer n, input integer d);
        op_div = dv;
        ma = a[7:0]; mb = b[7:0]; dn = n[15:0]; dd = d[7:0];
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    endtask

    task automatic run(input bit dv, input integer a, input integer b,
                       input integer n, input integer d);
        @(negedge clk);
        drive(dv, a, b, n, d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive(~dv, 8'h5A, 8'hA5, 16'h1357, 8'h3C);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0, "R9 busy", busy, 0);
        chk(done == 1'b0, "R9 done", done, 0);
        chk(word == 16'h0, "R9 word", word, 0);
        chk(rem == 8'h0, "R9 rem", rem, 0);
        rst_n = 1'b1;

        // R1 R2: multiply corners
        run(0, 8'h00, 8'hC3, 0, 0);
        run(0, 8'hFF, 8'hFF, 0, 0);
        run(0, 8'h80, 8'h02, 0, 0);
        run(0, 8'h01, 8'hFE, 0, 0);
        // R3 R4: divide corners
        run(1, 0, 0, 16'hFFFF, 8'h01);
        run(1, 0, 0, 16'd1234, 8'd7);
        run(1, 0, 0, 16'h0005, 8'hFF);
        run(1, 0, 0, 16'hFFFF, 8'hFF);
        // R5: divide by zero
        run(1, 0, 0, 16'hBEEF, 8'h00);
        run(1, 0, 0, 16'h0000, 8'h00);
        // R7: multiply after divide keeps remainder
        run(0, 8'h12, 8'h34, 0, 0);

        // R6: starts while busy are ignored
        @(negedge clk);
        drive(1, 0, 0, 16'd40000, 8'd13);
        start = 1'b1;
        @(negedge clk);
        drive(0, 8'hEE, 8'hDD, 0, 0);
        repeat (6) @(negedge clk);
        start = 1'b0;
        wait_done();

        // R8: start in the done cycle is accepted at once
        @(negedge clk);
        drive(0, 8'h9C, 8'h47, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        drive(1, 0, 0, 16'd999, 8'd10);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 back-to-back busy", busy, 1);
        wait_done();

        // R8: start held high across several done cycles
        @(negedge clk);
        drive(1, 8'h33, 8'h44, 16'hA5A5, 8'h00);
        start = 1'b1;
        repeat (90) @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (2) @(negedge clk);

        // Random mixes of both operations
        for (int k = 0; k < 60; k++) begin
            run($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 255),
                $urandom_range(0, 65535), (k % 7 == 0) ? 0 : $urandom_range(0, 255));
        end

        // R1: a multiply right after reset-time values
        run(0, 8'hAB, 8'hCD, 0, 0);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule